// File: doc/BRIEF.md
# I2C-Controlled Channel Select Switch Logic

This block is the digital control of a four-way bus switch. It acts as a target on an I2C bus and holds one control register. Each low bit of that register enables one downstream channel, and the enable outputs drive external pass gates. SCL and SDA are sampled with a fast system clock and pass through a synchronizer and a glitch filter. The block drives SDA only through an open-drain pull-low output.

A controller writes the register by addressing the target and sending data bytes. A new selection does not reach the enable outputs until the controller places a stop condition on the bus, so a channel is never connected in the middle of a transfer. A read returns the register in one byte. A bus-side active-low reset and the power-on reset each clear the register and the enables, and return the protocol engine to idle. The bus-side reset is how a system recovers when a downstream segment is stuck low.

Top module: `i2c_chan_switch`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits are 1110 followed by strap_i[2], strap_i[1], strap_i[0]. Bit 0 of that byte selects the direction: 1 is a read and 0 is a write. To acknowledge, it holds SDA low while SCL is high on the ninth clock.
- R2: When the address does not match, the target gives no acknowledge on that byte or on any byte after it. The register and the enables are left unchanged until the next start or stop.
- R3: Every data byte in a write is acknowledged. Its bits 3..0 are stored in the register and its bits 7..4 are discarded. chan_en_o keeps its previous value until a stop condition, and after the stop it equals the stored bits.
- R4: When a write carries several data bytes, the register keeps the last byte received.
- R5: A read shifts out one byte, MSB first, made of zeros in bits 7..4 and the register in bits 3..0. SDA changes only while SCL is low. The target releases SDA for the controller's acknowledge bit, sends the byte again after an ACK, and stops driving after a NACK.
- R6: While bus_rst_ni is low, the register and chan_en_o clear to zero, SDA is released, and the protocol engine returns to idle.
- R7: While rst_ni is low (power-on reset), chan_en_o is zero and SDA is released.
- R8: A pulse on SCL or SDA that lasts fewer than FILT_LEN system clocks has no effect on the protocol.
- R9: A repeated start restarts address reception. A write followed by a repeated start and a read returns the new value, and chan_en_o still holds the old selection until the stop.
- R10: Any combination of the four channel bits, from none to all, can be enabled at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| bus_rst_ni | input | 1 | Active-low recovery reset, sampled synchronously |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data from the bus (wired line) |
| strap_i | input | 3 | Address strap bits, low three bits of the address |
| sda_pull_o | output | 1 | 1 pulls SDA low (open drain) |
| chan_en_o | output | 4 | Channel enables, bit n enables channel n |

## Verification
The assertions rely on a well-formed controller. It changes SDA only while SCL is low, except to make a start or a stop. It never makes a start or a stop while the target is pulling SDA. It holds each SCL phase far longer than the filter length, so edges on the two lines stay in order after filtering. The bench drives every phase for 25 system clocks against a filter of 16. It places the deliberate glitches of 6 cycles only on SDA while SCL is high and on SCL while it is low. Stop and start conditions are made only when the target has released the line.

// File: rtl/i2csw_pkg.sv
package i2csw_pkg;
  localparam int unsigned NUM_CH = 4;
  localparam logic [3:0] ADDR_PREFIX = 4'b1110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_RACK,
    ST_SKIP
  } sw_state_e;
endpackage

// File: rtl/i2csw_filter.sv
module i2csw_filter #(
  parameter int unsigned FILT_LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic out_o
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          filt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      filt_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], in_i};
      if (sync_q[1] == filt_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_LEN - 1)) begin
        filt_q <= sync_q[1];
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign out_o = filt_q;

  // R8: the filtered level moves only to a value the synchronizer held
  a_r8_filter_follows_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_q != $past(filt_q)) |-> (filt_q == $past(sync_q[1])));
endmodule

// File: rtl/i2csw_target.sv
module i2csw_target
  import i2csw_pkg::*;
#(
  parameter int unsigned CH = NUM_CH
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_rst_ni,
  input  logic          scl_f_i,
  input  logic          sda_f_i,
  input  logic [2:0]    strap_i,
  output logic          sda_pull_o,
  output logic [CH-1:0] en_o
);
  localparam int unsigned PADW = 8 - CH;

  sw_state_e     state_q;
  logic [3:0]    cnt_q;
  logic [7:0]    sh_q;
  logic [7:0]    osh_q;
  logic          rw_q;
  logic          mack_q;
  logic          pend_q;
  logic [CH-1:0] ctrl_q;
  logic [CH-1:0] act_q;
  logic          scl_d, sda_d;

  logic scl_rise, scl_fall, start_det, stop_det, addr_hit;
  logic [7:0] rd_byte;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_f_i;
      sda_d <= sda_f_i;
    end
  end

  assign scl_rise  = scl_f_i & ~scl_d;
  assign scl_fall  = ~scl_f_i & scl_d;
  assign start_det = scl_f_i & scl_d & sda_d & ~sda_f_i;
  assign stop_det  = scl_f_i & scl_d & ~sda_d & sda_f_i;
  assign addr_hit  = (sh_q[7:1] == {ADDR_PREFIX, strap_i});
  assign rd_byte   = {{PADW{1'b0}}, ctrl_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      osh_q   <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      pend_q  <= 1'b0;
      ctrl_q  <= '0;
      act_q   <= '0;
    end else if (!bus_rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      ctrl_q  <= '0;
      act_q   <= '0;
    end else if (start_det) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
    end else if (stop_det) begin
      state_q <= ST_IDLE;
      if (pend_q) begin
        act_q  <= ctrl_q;
        pend_q <= 1'b0;
      end
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise) begin
            sh_q  <= {sh_q[6:0], sda_f_i};
            cnt_q <= cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            if (addr_hit) begin
              state_q <= ST_AACK;
              rw_q    <= sh_q[0];
            end else begin
              state_q <= ST_SKIP;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            cnt_q <= '0;
            if (rw_q) begin
              state_q <= ST_RDAT;
              osh_q   <= rd_byte;
            end else begin
              state_q <= ST_WDAT;
            end
          end
        end
        ST_WDAT: begin
          if (scl_rise) begin
            sh_q  <= {sh_q[6:0], sda_f_i};
            cnt_q <= cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            ctrl_q  <= sh_q[CH-1:0];
            pend_q  <= 1'b1;
            state_q <= ST_WACK;
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            state_q <= ST_WDAT;
            cnt_q   <= '0;
          end
        end
        ST_RDAT: begin
          if (scl_rise) begin
            cnt_q <= cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == 4'd8) state_q <= ST_RACK;
            else               osh_q   <= {osh_q[6:0], 1'b0};
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_f_i;
          end else if (scl_fall) begin
            if (mack_q) begin
              state_q <= ST_RDAT;
              osh_q   <= rd_byte;
              cnt_q   <= '0;
            end else begin
              state_q <= ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_pull_o = (state_q == ST_AACK) || (state_q == ST_WACK) ||
                      ((state_q == ST_RDAT) && !osh_q[7]);
  assign en_o = act_q;

  // R3: enables move only after a stop or a recovery reset
  a_r3_en_moves_on_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q != $past(act_q)) |-> ($past(stop_det) || !$past(bus_rst_ni)));

  // R4: register is written only at a falling SCL edge or by reset
  a_r4_ctrl_on_scl_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q != $past(ctrl_q)) |-> ($past(scl_fall) || !$past(bus_rst_ni)));

  // R5: the target never moves SDA while the filtered SCL is high
  a_r5_sda_moves_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni || !bus_rst_ni)
    (sda_pull_o != $past(sda_pull_o)) |-> !scl_f_i);

  // R6: recovery reset clears register and enables
  a_r6_bus_reset_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rst_ni |=> (ctrl_q == '0 && act_q == '0 && !sda_pull_o));
endmodule

// File: rtl/i2c_chan_switch.sv
module i2c_chan_switch
  import i2csw_pkg::*;
#(
  parameter int unsigned FILT_LEN = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  output logic              sda_pull_o,
  output logic [NUM_CH-1:0] chan_en_o
);
  logic [1:0] raw_lines;
  logic [1:0] filt_lines;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    i2csw_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .in_i  (raw_lines[g]),
      .out_o (filt_lines[g])
    );
  end

  i2csw_target #(.CH(NUM_CH)) u_target (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bus_rst_ni(bus_rst_ni),
    .scl_f_i   (filt_lines[0]),
    .sda_f_i   (filt_lines[1]),
    .strap_i   (strap_i),
    .sda_pull_o(sda_pull_o),
    .en_o      (chan_en_o)
  );
endmodule

// File: tb/i2c_chan_switch_bench.sv
module i2c_chan_switch_bench;
  localparam int Q = 25;

  logic       clk = 1'b0;
  logic       rst_ni, bus_rst_ni, scl, sda_drv;
  logic [2:0] strap;
  logic       sda_pull;
  logic [3:0] chan_en;
  logic       sda_line;

  int checks = 0;
  int fails  = 0;
  logic [3:0] m_ctrl = '0;
  logic [3:0] m_en   = '0;

  always #2 clk = ~clk;
  assign sda_line = sda_drv & ~sda_pull;

  i2c_chan_switch u_i2c_chan_switch (
    .clk_i(clk), .rst_ni(rst_ni), .bus_rst_ni(bus_rst_ni),
    .scl_i(scl), .sda_i(sda_line), .strap_i(strap),
    .sda_pull_o(sda_pull), .chan_en_o(chan_en)
  );

  function automatic logic [7:0] addr_byte(input logic [2:0] s, input logic rd);
    return {4'b1110, s, rd};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input logic b, output logic rb, input int gl);
    wq(Q); sda_drv = b;
    if (gl == 2) begin wq(5); scl = 1'b1; wq(6); scl = 1'b0; wq(Q - 11); end
    else wq(Q);
    scl = 1'b1;
    if (gl == 1 && b) begin wq(5); sda_drv = 1'b0; wq(6); sda_drv = 1'b1; wq(Q - 11); end
    else wq(Q);
    rb = sda_line;
    wq(Q); scl = 1'b0;
  endtask

  task automatic do_start;
    sda_drv = 1'b0; wq(Q); scl = 1'b0;
  endtask

  task automatic do_rstart;
    wq(Q); sda_drv = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_drv = 1'b0; wq(Q); scl = 1'b0;
  endtask

  task automatic do_stop;
    wq(Q); sda_drv = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_drv = 1'b1; wq(4 * Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack, input int gl);
    logic r;
    for (int i = 7; i >= 0; i--) put_bit(d[i], r, gl);
    put_bit(1'b1, r, 0);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      put_bit(1'b1, r, 0);
      d[i] = r;
    end
    put_bit(~mack, r, 0);
  endtask

  task automatic wr_tx(input int n, input logic [7:0] b0, input logic [7:0] b1,
                       input logic [7:0] b2, input int gl);
    logic ack;
    logic [7:0] bytes [3];
    bytes[0] = b0; bytes[1] = b1; bytes[2] = b2;
    do_start;
    send_byte(addr_byte(strap, 1'b0), ack, 0);
    chk("R1 write address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(bytes[i], ack, gl);
      chk("R3 data ack", ack, 1);
      m_ctrl = bytes[i][3:0];
    end
    chk("R3 enables held before stop", chan_en, m_en);
    do_stop;
    m_en = m_ctrl;
    chk("R3 R4 enables after stop", chan_en, m_en);
  endtask

  task automatic rd_tx(input int nbytes);
    logic ack;
    logic [7:0] d;
    do_start;
    send_byte(addr_byte(strap, 1'b1), ack, 0);
    chk("R1 read address ack", ack, 1);
    for (int i = 0; i < nbytes; i++) begin
      recv_byte(i != nbytes - 1, d);
      chk("R5 read data", d, {4'b0000, m_ctrl});
    end
    chk("R5 released after nack", sda_pull, 0);
    do_stop;
  endtask

  task automatic miss_tx;
    logic ack;
    logic [6:0] a;
    do begin
      a = 7'($urandom);
    end while (a == {4'b1110, strap});
    do_start;
    send_byte({a, 1'b0}, ack, 0);
    chk("R2 no ack on mismatch", ack, 0);
    send_byte(8'hFF, ack, 0);
    chk("R2 no ack after mismatch", ack, 0);
    do_stop;
    chk("R2 enables unchanged", chan_en, m_en);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    void'($urandom(32'd4242));
    rst_ni = 1'b0; bus_rst_ni = 1'b1; scl = 1'b1; sda_drv = 1'b1; strap = 3'b101;
    wq(10);
    chk("R7 enables in power-on reset", chan_en, 0);
    chk("R7 sda released in reset", sda_pull, 0);
    rst_ni = 1'b1;
    wq(4 * Q);

    wr_tx(1, 8'hF5, 8'h00, 8'h00, 0);              // R3 upper bits dropped
    rd_tx(1);                                      // R5
    wr_tx(3, 8'hA3, 8'h0C, 8'hF6, 0);              // R4 last byte kept
    rd_tx(2);                                      // R5 repeat after ack

    // R9: write, repeated start, read back before the stop
    do_start;
    send_byte(addr_byte(strap, 1'b0), ack, 0);
    chk("R9 addr ack", ack, 1);
    send_byte(8'h09, ack, 0);
    chk("R9 data ack", ack, 1);
    m_ctrl = 4'h9;
    do_rstart;
    send_byte(addr_byte(strap, 1'b1), ack, 0);
    chk("R9 restart addr ack", ack, 1);
    recv_byte(1'b0, d);
    chk("R9 new value read", d, 8'h09);
    chk("R9 old selection held", chan_en, m_en);
    do_stop;
    m_en = m_ctrl;
    chk("R9 applied at stop", chan_en, 4'h9);

    miss_tx;                                       // R2

    wr_tx(1, 8'h0B, 8'h00, 8'h00, 1);              // R8 sda glitches
    wr_tx(1, 8'h04, 8'h00, 8'h00, 2);              // R8 scl glitches

    for (int v = 0; v < 16; v++) wr_tx(1, 8'(v), 8'h00, 8'h00, 0); // R10

    // R6: recovery reset in the middle of a write
    do_start;
    send_byte(addr_byte(strap, 1'b0), ack, 0);
    send_byte(8'h03, ack, 0);
    bus_rst_ni = 1'b0; wq(20);
    chk("R6 enables cleared", chan_en, 0);
    chk("R6 sda released", sda_pull, 0);
    bus_rst_ni = 1'b1;
    m_ctrl = '0; m_en = '0;
    wq(Q); scl = 1'b1; wq(4 * Q);
    rd_tx(1);

    for (int k = 0; k < 12; k++) begin
      strap = 3'($urandom);
      wq(4 * Q);
      case ($urandom_range(0, 2))
        0: wr_tx($urandom_range(1, 3), 8'($urandom), 8'($urandom), 8'($urandom), 0);
        1: rd_tx($urandom_range(1, 2));
        default: miss_tx;
      endcase
    end

    wr_tx(1, 8'h0E, 8'h00, 8'h00, 0);
    rst_ni = 1'b0; wq(5);
    chk("R7 power-on reset clears enables", chan_en, 0);
    rst_ni = 1'b1; m_ctrl = '0; m_en = '0;
    wq(4 * Q);
    rd_tx(1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule